// File: doc/BRIEF.md
# Cycle Counter Compare Timer

The block keeps a free-running cycle counter and a parameterised set of compare registers. Each compare register owns one interrupt-pending bit. When the counter arrives at a compare value, that slot's pending bit rises and holds until software rewrites the compare register, rewrites the counter, or pulses the slot's clear input. A single write port serves all registers: a select picks the target and a write enable commits the data word.

Every match is measured as a forward distance from the moment a register was last written. That distance is modulo the counter range and is never zero. A compare value equal to the counter at the moment it is written therefore fires only after a full wrap. Likewise, after the counter is loaded with a value already held in a compare register, that compare fires only after a full wrap. Reset behaves like a load of zero into every register.

Top module: `cycle_compare_timer`

## Requirements
- R1: `count` increases by exactly one on every clock edge without a write to it, and wraps from all ones to zero.
- R2: Select code 0 addresses the counter and code k+1 addresses compare slot k. A write with any code above NUM_CMP changes no counter, compare or pending state.
- R3: When `count` equals compare slot k on a clock edge, with no write, load or clear affecting slot k on that edge, `pending[k]` is 1 from the next cycle on. The other slots are unaffected.
- R4: A set pending bit stays 1 while the counter moves past the compare value, until one of the clear events in R5, R7 or R8 occurs.
- R5: A write to compare slot k updates that slot in the next cycle and clears `pending[k]` in the same cycle.
- R6: A compare written with the value `count` shows during the write cycle does not fire until a full counter wrap. A compare written with that value plus one fires on the following edge.
- R7: A counter write makes `count` equal the data in the next cycle and clears every pending bit. A compare equal to the loaded value does not fire on the cycle after the load. Compares ahead of the loaded value fire when the counter reaches them.
- R8: A 1 on `clrPend[k]` for one cycle clears `pending[k]` in the next cycle, taking priority over a match on that same edge.
- R9: A synchronous active-high `rst` sets the counter, all compare slots and all pending bits to zero. Zeroed compares do not fire in the cycles just after reset.
- R10: `cmpVals` carries compare slot k in bits [32k+31 : 32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write enable for the register port |
| wrSel | input | SEL_W (3) | Target select: 0 counter, k+1 compare slot k |
| wrData | input | CNT_W (32) | Write data |
| clrPend | input | NUM_CMP (3) | Per-slot pending clear |
| count | output | CNT_W (32) | Current counter value |
| cmpVals | output | NUM_CMP*CNT_W (96) | Packed compare values |
| pending | output | NUM_CMP (3) | Interrupt-pending bits |

## Verification
Matches are tested with compares placed a few cycles ahead of a freshly loaded counter. The test watches the exact cycle in which the pending bit rises, which separates a match that is late by one cycle from a match that is early by one cycle. Two slots are armed at different distances, to show that each slot's bit is independent. The equal-value cases are tested next to the plus-one case. A compare written to the current count and a counter loaded onto an existing compare must both stay silent, while the plus-one write must fire at once. This pins down the nonzero-distance rule against an off-by-one. Writes with unused select codes, the wrap at all ones, and the clear input racing a match cover the remaining edges.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int MAX_CMP = 8;

  typedef struct packed {
    logic               loadCount;
    logic               matchMask;
    logic [MAX_CMP-1:0] cmpWr;
  } cctStrobes_t;
endpackage

// File: rtl/cct_ctrl.sv
module cct_ctrl #(
  parameter int NUM_CMP = 3,
  parameter int SEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  output cct_pkg::cctStrobes_t strobes
);
  logic maskQ;

  always_comb begin
    strobes = '0;
    strobes.loadCount = wrEn && (wrSel == '0);
    for (int k = 0; k < NUM_CMP; k++) begin
      strobes.cmpWr[k] = wrEn && (wrSel == SEL_W'(k + 1));
    end
    strobes.matchMask = maskQ;
  end

  // a load (or reset) makes the cycle that shows the loaded value non-matching
  always_ff @(posedge clk) begin
    if (rst) maskQ <= 1'b1;
    else     maskQ <= strobes.loadCount;
  end

  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.loadCount, strobes.cmpWr}));

  a_r2_unused_code: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (int'(wrSel) > NUM_CMP)) |-> (!strobes.loadCount && strobes.cmpWr == '0));
endmodule

// File: rtl/cct_datapath.sv
module cct_datapath #(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  cct_pkg::cctStrobes_t     strobes,
  input  logic [CNT_W-1:0]         wrData,
  input  logic [NUM_CMP-1:0]       clrPend,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_CMP*CNT_W-1:0] cmpVals,
  output logic [NUM_CMP-1:0]       pending
);
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (rst)                    countQ <= '0;
    else if (strobes.loadCount) countQ <= wrData;
    else                        countQ <= countQ + 1'b1;
  end

  assign count = countQ;

  for (genvar k = 0; k < NUM_CMP; k++) begin : gSlot
    logic [CNT_W-1:0] cmpQ;
    logic             pendQ;
    logic             hit;

    assign hit = (countQ == cmpQ) && !strobes.matchMask;

    always_ff @(posedge clk) begin
      if (rst)                   cmpQ <= '0;
      else if (strobes.cmpWr[k]) cmpQ <= wrData;
    end

    always_ff @(posedge clk) begin
      if (rst)                                                   pendQ <= 1'b0;
      else if (strobes.loadCount || strobes.cmpWr[k] || clrPend[k]) pendQ <= 1'b0;
      else if (hit)                                              pendQ <= 1'b1;
    end

    assign cmpVals[k*CNT_W +: CNT_W] = cmpQ;
    assign pending[k] = pendQ;

    a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
      strobes.cmpWr[k] |=> (!pending[k] && cmpVals[k*CNT_W +: CNT_W] == $past(wrData)));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
      clrPend[k] |=> !pending[k]);

    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
      (pending[k] && !strobes.loadCount && !strobes.cmpWr[k] && !clrPend[k]) |=> pending[k]);

    a_r3_match_sets: assert property (@(posedge clk) disable iff (rst)
      ((count == cmpVals[k*CNT_W +: CNT_W]) && !strobes.matchMask && !strobes.loadCount
       && !strobes.cmpWr[k] && !clrPend[k]) |=> pending[k]);
  end

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadCount |=> (count == $past(count) + 1'b1));

  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    strobes.loadCount |=> (count == $past(wrData) && pending == '0));

  a_r7_masked_no_fire: assert property (@(posedge clk) disable iff (rst)
    strobes.matchMask |=> (pending == '0));
endmodule

// File: rtl/cycle_compare_timer.sv
module cycle_compare_timer #(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  localparam int SEL_W  = $clog2(NUM_CMP + 2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [CNT_W-1:0]         wrData,
  input  logic [NUM_CMP-1:0]       clrPend,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_CMP*CNT_W-1:0] cmpVals,
  output logic [NUM_CMP-1:0]       pending
);
  cct_pkg::cctStrobes_t strobes;

  initial begin
    if (NUM_CMP < 1 || NUM_CMP > cct_pkg::MAX_CMP)
      $error("NUM_CMP out of range");
  end

  cct_ctrl #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .strobes(strobes)
  );

  cct_datapath #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .clrPend(clrPend), .count(count), .cmpVals(cmpVals), .pending(pending)
  );
endmodule

// File: tb/sim_cycle_compare_timer.sv
`timescale 1ns/1ps
module sim_cycle_compare_timer;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [NC-1:0] clrPend = '0;
  logic [31:0] count;
  logic [NC*32-1:0] cmpVals;
  logic [NC-1:0] pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cycle_compare_timer u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .clrPend(clrPend), .count(count), .cmpVals(cmpVals), .pending(pending)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive at a negedge, effect visible at the next negedge
  task automatic wrReg(input logic [2:0] sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R9 count in reset", 96'(count), 96'(0));
    chk("R9 cmp in reset", 96'(cmpVals), 96'(0));
    rst = 1'b0;
    step(1);
    chk("R9 count after reset", 96'(count), 96'(1));
    step(5);
    chk("R9 zero compares silent", 96'(pending), 96'(0));
  endtask

  task automatic tWrap();
    wrReg(3'd0, 32'hFFFF_FFFE);
    chk("R7 load value", 96'(count), 96'(32'hFFFF_FFFE));
    step(1);
    chk("R1 step", 96'(count), 96'(32'hFFFF_FFFF));
    step(1);
    chk("R1 wrap", 96'(count), 96'(0));
  endtask

  task automatic tMatch();
    wrReg(3'd0, 32'd100);
    wrReg(3'd1, 32'd105);          // count now 101
    wrReg(3'd2, 32'd103);          // count now 102
    chk("R10 slot0 field", 96'(cmpVals[31:0]), 96'(105));
    chk("R10 slot1 field", 96'(cmpVals[63:32]), 96'(103));
    step(1);                       // count 103
    chk("R3 not early", 96'(pending), 96'(0));
    step(1);                       // count 104
    chk("R3 slot1 only", 96'(pending), 96'(3'b010));
    step(1);                       // count 105
    chk("R3 slot0 not early", 96'(pending), 96'(3'b010));
    step(1);                       // count 106
    chk("R3 slot0 fires", 96'(pending), 96'(3'b011));
    step(5);
    chk("R4 sticky", 96'(pending), 96'(3'b011));
  endtask

  task automatic tCmpWrite();
    wrReg(3'd1, 32'd7);
    chk("R5 write clears slot0", 96'(pending), 96'(3'b010));
    chk("R5 value stored", 96'(cmpVals[31:0]), 96'(7));
  endtask

  task automatic tIgnored();
    logic [95:0] cv;
    logic [31:0] c;
    cv = cmpVals; c = count;
    wrReg(3'd4, 32'd55);
    chk("R2 code4 count", 96'(count), 96'(c + 1));
    wrReg(3'd7, 32'd55);
    chk("R2 code7 count", 96'(count), 96'(c + 2));
    chk("R2 compares kept", cmpVals, cv);
    chk("R2 pending kept", 96'(pending), 96'(3'b010));
  endtask

  task automatic tLoad();
    wrReg(3'd0, 32'd500);
    chk("R7 load clears all", 96'(pending), 96'(0));
    wrReg(3'd3, 32'd600);          // count 501
    wrReg(3'd1, 32'd700);
    wrReg(3'd0, 32'd600);          // slot2 equals loaded value
    step(3);
    chk("R7 equal load silent", 96'(pending), 96'(0));
    wrReg(3'd0, 32'd698);
    step(2);                       // count 700, edge not yet
    chk("R7 before reevaluated match", 96'(pending), 96'(0));
    step(1);
    chk("R7 reevaluated match", 96'(pending), 96'(3'b001));
  endtask

  task automatic tEqual();
    logic [31:0] c;
    wrReg(3'd0, 32'd1000);
    c = count;
    wrReg(3'd2, c);
    step(20);
    chk("R6 equal write silent", 96'(pending[1]), 96'(0));
    c = count;
    wrReg(3'd3, c + 1);
    chk("R6 plus one shows", 96'(count), 96'(c + 1));
    step(1);
    chk("R6 plus one fires", 96'(pending[2]), 96'(1));
  endtask

  task automatic tClear();
    logic [31:0] c;
    clrPend = 3'b100;
    step(1);
    clrPend = '0;
    chk("R8 clear", 96'(pending[2]), 96'(0));
    c = count;
    wrReg(3'd1, c + 2);            // count c+1
    step(1);                       // count c+2, match on next edge
    clrPend = 3'b001;
    step(1);
    clrPend = '0;
    chk("R8 clear beats match", 96'(pending[0]), 96'(0));
    step(3);
    chk("R8 stays clear", 96'(pending[0]), 96'(0));
  endtask

  initial begin
    step(3);
    tReset();
    tWrap();
    tMatch();
    tCmpWrite();
    tIgnored();
    tLoad();
    tEqual();
    tClear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule